// File: doc/BRIEF.md
# Card Slot Status Change Interrupt Unit

This block watches the status pins of two removable-card slots and turns their activity into one interrupt request. Each slot has eight raw status pins (two voltage-sense pins, write protect, two card-detect pins, two battery-voltage pins and ready). The pins pass through a synchronizer. Three shared 32-bit registers hold the results. The pin register shows the current levels. The change register latches edges and is cleared by writing ones. The enable register selects which change bits may raise the interrupt. Slot A uses the upper half of each register and slot B uses the lower half, in the same layout.

The ready pin feeds four sources. Rising-edge and falling-edge sources are latched like the other change bits. Two level sources, ready-low and ready-high, follow the synchronized pin and cannot be cleared. A card-detect change is only reported once both detect pins of the slot agree, so a card that is half inserted raises no interrupt. Each slot also has a small control register that drives the card reset and the active-low buffer enable.

Top module: `slot_irq_unit`

## Requirements
- R1: After reset the change register holds no latched bits, the enable register is zero, both card resets are 0, both buffer enables (active low) are 1, and `irq` is 0.
- R2: The pin register (address 0) shows slot A raw pins on bits 31:24 and slot B raw pins on bits 15:8, with all other bits 0. The pin input order is bit 7 VS1, 6 VS2, 5 WP, 4 CD2, 3 CD1, 2 BVD2, 1 BVD1, 0 RDY. A pin change appears two cycles after it is sampled.
- R3: Any edge on a synchronized VS, WP or BVD pin sets the matching change bit (address 1), at the pin register's position for that pin, and the bit stays set.
- R4: A write to the change register clears each latched bit written as 1 and leaves every bit written as 0 unchanged.
- R5: A card-detect change sets both detect change bits of the slot (bits 28 and 27 for slot A), and only when the synchronized CD1 and CD2 pins are equal after the change.
- R6: An edge on ready sets the ready change bit (bit 24 for slot A). A rising edge also sets bit 21 and a falling edge also sets bit 20.
- R7: Bit 23 (ready-low) and bit 22 (ready-high) of slot A read the current synchronized ready level. A write of ones to the change register does not clear them.
- R8: `irq` is 1 exactly when some bit set in the change register view (latched or level) is also set in the enable register (address 2). The enable register reads back as written.
- R9: In the control registers (address 3 for slot A, 4 for slot B), bit 6 drives `card_rst` (1 = reset asserted) and bit 7 drives `buf_oe_n`. Both bits read back and the other bits read 0. Index 0 of the output vectors is slot A.
- R10: Slot B behaves like slot A with every register bit position moved 16 places lower.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pins_a | input | 8 | Raw status pins of slot A |
| pins_b | input | 8 | Raw status pins of slot B |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 pin, 1 change, 2 enable, 3 control A, 4 control B |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the selected register (combinational) |
| irq | output | 1 | Interrupt request |
| card_rst | output | 2 | Card reset per slot |
| buf_oe_n | output | 2 | Active-low buffer enable per slot |

## Verification
The hardest case to reach is a card-detect edge that must be suppressed: one detect pin changes while the other has not yet followed. The bench moves CD2 alone and checks that no detect change latches. It then moves CD1 so both agree and checks that both bits latch together. It also drives the ready pin low and high and writes all ones to the change register. This shows that the two level sources survive the clear while the edge sources do not.

// File: rtl/slot_irq_pkg.sv
package slot_irq_pkg;
  localparam int SLOTS = 2;
  localparam int HALF  = 16;
  localparam int PINS  = 8;
  localparam int DW    = SLOTS * HALF;

  // raw pin index inside one slot's pin vector
  localparam int P_VS1 = 7, P_VS2 = 6, P_WP = 5, P_CD2 = 4;
  localparam int P_CD1 = 3, P_BVD2 = 2, P_BVD1 = 1, P_RDY = 0;

  // bit positions inside one half of the change register
  localparam int H_PIN0 = 8;
  localparam int H_RLO  = 7;
  localparam int H_RHI  = 6;
  localparam int H_RISE = 5;
  localparam int H_FALL = 4;

  localparam logic [HALF-1:0] HALF_CLR_MASK = 16'hFF30;
  localparam logic [DW-1:0]   CLR_MASK      = {SLOTS{HALF_CLR_MASK}};

  typedef enum logic [2:0] {
    A_PIN  = 3'd0,
    A_CHG  = 3'd1,
    A_EN   = 3'd2,
    A_CTLA = 3'd3,
    A_CTLB = 3'd4
  } reg_addr_e;

  // lowest register bit of a slot's half
  function automatic int slot_base(input int s);
    return (SLOTS - 1 - s) * HALF;
  endfunction

  // latched events of one slot from new and previous synchronized pins
  function automatic logic [HALF-1:0] half_events(input logic [PINS-1:0] now,
                                                  input logic [PINS-1:0] old);
    logic [PINS-1:0] edg;
    logic [HALF-1:0] ev;
    logic            cd_ok;
    edg = now ^ old;
    ev  = '0;
    ev[H_PIN0 +: PINS] = edg;
    cd_ok = (now[P_CD1] == now[P_CD2]) && (edg[P_CD1] || edg[P_CD2]);
    ev[H_PIN0 + P_CD1] = cd_ok;
    ev[H_PIN0 + P_CD2] = cd_ok;
    ev[H_RISE] = edg[P_RDY] & now[P_RDY];
    ev[H_FALL] = edg[P_RDY] & ~now[P_RDY];
    return ev;
  endfunction

  // level sources of one slot
  function automatic logic [HALF-1:0] half_levels(input logic rdy);
    logic [HALF-1:0] lv;
    lv = '0;
    lv[H_RLO] = ~rdy;
    lv[H_RHI] = rdy;
    return lv;
  endfunction
endpackage

// File: rtl/slot_pin_sync.sv
module slot_pin_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] stg [STAGES+1];

  for (genvar i = 0; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= '0;
      else if (i == 0) stg[i] <= d;
      else stg[i] <= stg[(i == 0) ? 0 : i-1];
    end
  end

  assign q      = stg[STAGES-1];
  assign q_prev = stg[STAGES];
endmodule

// File: rtl/slot_evt.sv
module slot_evt
  import slot_irq_pkg::*;
(
  input  logic [PINS-1:0] now,
  input  logic [PINS-1:0] old,
  output logic [HALF-1:0] set_half,
  output logic [HALF-1:0] lvl_half,
  output logic [HALF-1:0] pin_half
);
  assign set_half = half_events(now, old);
  assign lvl_half = half_levels(now[P_RDY]);
  assign pin_half = {now, {(HALF-PINS){1'b0}}};
endmodule

// File: rtl/slot_irq_unit.sv
module slot_irq_unit
  import slot_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  pins_a,
  input  logic [7:0]  pins_b,
  input  logic        wr_en,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        irq,
  output logic [1:0]  card_rst,
  output logic [1:0]  buf_oe_n
);
  localparam int RAW_W = SLOTS * PINS;

  logic [RAW_W-1:0] sync_vec, prev_vec;
  logic [DW-1:0]    set_vec, lvl_vec, pin_vec;
  logic [DW-1:0]    chg_q, chg_view, en_q, clr_vec;
  logic [1:0]       ctl_q [SLOTS];   // {oe_n, rst}
  logic             wr_chg;

  slot_pin_sync #(.W(RAW_W), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({pins_a, pins_b}),
    .q(sync_vec), .q_prev(prev_vec)
  );

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam int RB = (SLOTS - 1 - s) * PINS;
    localparam int HB = (SLOTS - 1 - s) * HALF;
    slot_evt u_evt (
      .now(sync_vec[RB +: PINS]), .old(prev_vec[RB +: PINS]),
      .set_half(set_vec[HB +: HALF]), .lvl_half(lvl_vec[HB +: HALF]),
      .pin_half(pin_vec[HB +: HALF])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_q[s] <= 2'b10;
      else if (wr_en && reg_addr == 3'(A_CTLA + s)) ctl_q[s] <= wr_data[7:6];
    end
    assign card_rst[s] = ctl_q[s][0];
    assign buf_oe_n[s] = ctl_q[s][1];
  end

  assign wr_chg  = wr_en && (reg_addr == A_CHG);
  assign clr_vec = wr_chg ? (wr_data & CLR_MASK) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_q <= '0;
      en_q  <= '0;
    end else begin
      chg_q <= ((chg_q & ~clr_vec) | set_vec) & CLR_MASK;
      if (wr_en && reg_addr == A_EN) en_q <= wr_data;
    end
  end

  assign chg_view = chg_q | lvl_vec;
  assign irq      = |(chg_view & en_q);

  always_comb begin
    case (reg_addr)
      A_PIN:   rd_data = pin_vec;
      A_CHG:   rd_data = chg_view;
      A_EN:    rd_data = en_q;
      A_CTLA:  rd_data = {24'h0, ctl_q[0], 6'h0};
      A_CTLB:  rd_data = {24'h0, ctl_q[1], 6'h0};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/slot_irq_chk.sv
module slot_irq_chk
  import slot_irq_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  reg_addr,
  input logic [31:0] wr_data,
  input logic [31:0] chg_q,
  input logic [31:0] set_vec,
  input logic [31:0] en_q,
  input logic [15:0] sync_vec,
  input logic        irq,
  input logic [1:0]  card_rst,
  input logic [1:0]  buf_oe_n
);
  p_set_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((chg_q & $past(set_vec)) == $past(set_vec)));

  p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_addr == A_CHG) |=>
      ((chg_q & $past(wr_data & CLR_MASK) & ~$past(set_vec)) == 32'h0));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && reg_addr == A_CHG) |=> ((chg_q & $past(chg_q)) == $past(chg_q)));

  p_cd_agree_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[28] |-> (sync_vec[12] == sync_vec[11]));

  p_cd_agree_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[12] |-> (sync_vec[4] == sync_vec[3]));

  p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == 32'h0) |-> !irq);

  p_ctl_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_addr == A_CTLA) |=>
      (card_rst[0] == $past(wr_data[6]) && buf_oe_n[0] == $past(wr_data[7])));
endmodule

bind slot_irq_unit slot_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
  .wr_data(wr_data), .chg_q(chg_q), .set_vec(set_vec), .en_q(en_q),
  .sync_vec(sync_vec), .irq(irq), .card_rst(card_rst), .buf_oe_n(buf_oe_n)
);

// File: tb/slot_irq_unit_tb.sv
module slot_irq_unit_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  pins_a = 0, pins_b = 0;
  logic        wr_en = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic        irq;
  logic [1:0]  card_rst, buf_oe_n;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  slot_irq_unit u_dut (.*);

  // {pins_a, pins_b, expected pin register}
  localparam logic [47:0] VEC [5] = '{
    {8'hA5, 8'h3C, 32'hA500_3C00},
    {8'hFF, 8'h00, 32'hFF00_0000},
    {8'h00, 8'hFF, 32'h0000_FF00},
    {8'h18, 8'h81, 32'h1800_8100},
    {8'h00, 8'h00, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; reg_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = rd_data;
  endtask

  task automatic set_pins(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk); pins_a = a; pins_b = b;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(1, v); chk("R1 change", v, 32'h0080_0080);
    rd(2, v); chk("R1 enable", v, 32'h0);
    chk("R1 card_rst", {30'h0, card_rst}, 32'h0);
    chk("R1 buf_oe_n", {30'h0, buf_oe_n}, 32'h3);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R2 table walk
    foreach (VEC[i]) begin
      set_pins(VEC[i][47:40], VEC[i][39:32]);
      rd(0, v); chk("R2 pin register", v, VEC[i][31:0]);
    end
    wr(1, 32'hFFFF_FFFF);
    rd(1, v); chk("R4 clear all", v, 32'h0080_0080);

    // R3 WP edge slot A
    set_pins(8'h20, 8'h00);
    rd(1, v); chk("R3 WP change", v, 32'h2080_0080);
    wr(1, 32'h0);
    rd(1, v); chk("R4 zero write keeps", v, 32'h2080_0080);
    wr(1, 32'h2000_0000);
    rd(1, v); chk("R4 one write clears", v, 32'h0080_0080);

    // R10 slot B mirror
    set_pins(8'h20, 8'h20);
    rd(1, v); chk("R10 slot B WP", v, 32'h0080_2080);
    wr(1, 32'h0000_2000);

    // R5 card detect agreement
    set_pins(8'h30, 8'h20);
    rd(1, v); chk("R5 disagree ignored", v, 32'h0080_0080);
    set_pins(8'h38, 8'h20);
    rd(1, v); chk("R5 agree sets both", v, 32'h1880_0080);
    wr(1, 32'hFFFF_FFFF);

    // R6 / R7 ready sources
    set_pins(8'h39, 8'h20);
    rd(1, v); chk("R6 ready rise", v, 32'h0160_0080);
    wr(1, 32'hFFFF_FFFF);
    rd(1, v); chk("R7 ready-high kept", v, 32'h0040_0080);
    set_pins(8'h38, 8'h20);
    rd(1, v); chk("R6 ready fall", v, 32'h0190_0080);
    wr(1, 32'hFFFF_FFFF);
    rd(1, v); chk("R7 ready-low kept", v, 32'h0080_0080);

    // R8 interrupt masking
    wr(2, 32'h0080_0000);
    @(negedge clk); chk("R8 level irq", {31'h0, irq}, 32'h1);
    wr(2, 32'h2000_0000);
    @(negedge clk); chk("R8 masked", {31'h0, irq}, 32'h0);
    set_pins(8'h18, 8'h20);
    chk("R8 WP irq", {31'h0, irq}, 32'h1);
    wr(2, 32'h0000_2000);
    @(negedge clk); chk("R8 other bit", {31'h0, irq}, 32'h0);
    rd(2, v); chk("R8 enable readback", v, 32'h0000_2000);

    // R9 control
    wr(3, 32'h0000_0040);
    @(negedge clk);
    chk("R9 card_rst A", {30'h0, card_rst}, 32'h1);
    chk("R9 buf_oe_n A", {30'h0, buf_oe_n}, 32'h2);
    rd(3, v); chk("R9 ctl A readback", v, 32'h40);
    wr(4, 32'hFFFF_FFC0);
    @(negedge clk);
    chk("R9 card_rst B", {30'h0, card_rst}, 32'h3);
    rd(4, v); chk("R9 ctl B readback", v, 32'hC0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule